// File: doc/BRIEF.md
# Interrupt Distributor

The distributor collects interrupt lines and sends each one to a chosen set of CPU interfaces. Three kinds of source share one ID space. IDs 0 to 15 are raised only by software, through a register write that names a list of CPUs. IDs 16 to 31 are private lines, one set of sixteen per CPU. IDs 32 and up are device lines that all CPUs share. The enable bits and the pending state of IDs 0 to 31 are kept separately for each CPU. Each device line has its own enable bit, its own trigger type and a 16-bit target field that picks which CPUs see it.

Software reaches the block over a single-cycle register bus. A write takes effect at the clock edge. A read returns data in the same cycle and changes nothing. Every access carries the number of the CPU that makes it, and that number selects the private bank. For each CPU the block drives a vector that has one bit per ID. A bit is set when forwarding is on, the ID is enabled and pending, and the ID targets that CPU. The CPU interface clears a latched interrupt by presenting an acknowledge together with the ID.

Top module: `irq_dist`

## Requirements
- R1: After a synchronous active-low reset the following are all zero: forwarding, every enable, every pending state, every device target field and every trigger bit of IDs 16 and up. The pending vector is all zero.
- R2: A write of a one to bit (id mod 32) sets the enable of an ID. The word for enable set is at byte 0x100 + (id/32)*4, and the word for enable clear is at 0x180 + (id/32)*4. A written zero changes nothing. Either address reads back the current enables.
- R3: The trigger words sit at 0x200 + (id/32)*4, with bit (id mod 32) set to 1 for rising edge and 0 for active-high level. IDs 0 to 15 always read 1, and writes to those bits are ignored.
- R4: A level-type line shows as pending one clock after it goes high and stops one clock after it goes low, and an acknowledge does not affect it. An edge-type line latches pending one clock after a rising edge and holds it until an acknowledge. If a new rising edge arrives in the same cycle as the acknowledge, the interrupt stays pending.
- R5: The target field of a device ID is held in the word at 0x400 + ((id*2) & ~3). An even ID uses bits [15:0] and an odd ID uses bits [31:16]. Bit c of the field routes the ID to CPU c. Bits for CPUs at or above NUM_CPU read as 0.
- R6: The target words of IDs 0 to 31 read back as the one-hot bit of the requesting CPU in both halves, and writes to them are ignored. A private ID reaches only the CPU that owns it.
- R7: The read-only word at 0x004 holds NUM_IRQ/32 - 1 in bits [4:0], with 0 in all other bits. Writes to it change nothing.
- R8: Bit 0 of the word at 0x000 turns forwarding on. While it is 0 the pending vector is all zero, but lines still latch pending and show once forwarding is turned back on.
- R9: A write to 0x800 makes ID bits [3:0] pending for every CPU c whose bit [8+c] is set. An acknowledge from CPU c clears it for that CPU only. When a raise and an acknowledge fall in the same cycle, the raise wins.
- R10: The enables and pending state of IDs 0 to 31 are kept per CPU. A bus access selects the bank of bus_cpu. The private line of CPU c for ID 16+j is loc_irq[c*16+j].
- R11: pend_vec[c*NUM_IRQ+id] is 1 exactly when forwarding is on, the ID is enabled and pending in the relevant bank, and, for IDs 32 and up, target bit c is set.
- R12: An acknowledge of a device edge ID from any CPU clears its latched pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPU_W | Number of the CPU making the access |
| bus_rdata | output | 32 | Read data for bus_addr, in the same cycle |
| dev_irq | input | NUM_IRQ-32 | Shared device lines for IDs 32 and up |
| loc_irq | input | NUM_CPU*16 | Private lines, sixteen per CPU, for IDs 16 to 31 |
| ack_vld | input | NUM_CPU | Acknowledge strobe, one per CPU |
| ack_id | input | NUM_CPU*ID_W | ID being acknowledged, one field per CPU |
| pend_vec | output | NUM_CPU*NUM_IRQ | Forwarded pending bits, NUM_IRQ bits per CPU |

## Verification
The bench targets the cycles where two causes meet. In one case an edge or a software raise arrives in the same cycle as an acknowledge, and a design with the priority reversed would lose that interrupt. In another an acknowledge of a level line comes while the line is still high, and a design that wrongly clears level lines would drop the bit for a cycle. A second group covers banking and routing. A software raise reaches a CPU that has not enabled the ID, a private line is enabled on the wrong CPU, and target bits are written above NUM_CPU. A design that shares banks or leaks a private line would show the bit on the wrong CPU. Writes are aimed at the fixed trigger bits, the private target words and the type word, and a design that lets them through would read back changed values. Forwarding is switched off while an edge arrives, which exposes a design that gates the latch instead of only the output.

// File: rtl/irq_dist.sv
module irq_dist #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  parameter int AW = 12,
  localparam int ID_W = $clog2(NUM_IRQ),
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [AW-1:0]              bus_addr,
  input  logic [31:0]                bus_wdata,
  input  logic [CPU_W-1:0]           bus_cpu,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_IRQ-33:0]        dev_irq,
  input  logic [NUM_CPU*16-1:0]      loc_irq,
  input  logic [NUM_CPU-1:0]         ack_vld,
  input  logic [NUM_CPU*ID_W-1:0]    ack_id,
  output logic [NUM_CPU*NUM_IRQ-1:0] pend_vec
);

  localparam int NW    = NUM_IRQ / 32;
  localparam int NDEV  = NUM_IRQ - 32;
  localparam int NPAIR = NUM_IRQ / 2;

  localparam logic [AW-1:0] A_CTRL = AW'('h000);
  localparam logic [AW-1:0] A_TYPE = AW'('h004);
  localparam logic [AW-1:0] A_ESET = AW'('h100);
  localparam logic [AW-1:0] A_ECLR = AW'('h180);
  localparam logic [AW-1:0] A_TRIG = AW'('h200);
  localparam logic [AW-1:0] A_TGT  = AW'('h400);
  localparam logic [AW-1:0] A_SWI  = AW'('h800);

  logic                           fwd;
  logic [NUM_CPU-1:0][31:0]       loc_en;
  logic [NUM_CPU-1:0][15:0]       sw_pend;
  logic [NUM_CPU-1:0][15:0]       loc_q;
  logic [NUM_CPU-1:0][15:0]       loc_edge;
  logic [NUM_IRQ-1:16]            trig;
  logic [NDEV-1:0]                dev_en;
  logic [NDEV-1:0]                dev_q;
  logic [NDEV-1:0]                dev_edge;
  logic [NUM_CPU-1:0]             dev_tgt [NDEV];

  logic [NUM_IRQ-1:0]             eset_m;
  logic [NUM_IRQ-1:0]             eclr_m;
  logic [NW-1:0]                  trig_hit;
  logic [NDEV-1:0]                tgt_we;
  logic [NUM_CPU-1:0]             tgt_wv [NDEV];
  logic [NUM_CPU-1:0][15:0]       sw_set;
  logic [NUM_CPU-1:0][31:0]       loc_ack;
  logic [NDEV-1:0]                dev_ack;
  logic [NDEV-1:0]                dev_pend;

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_swi  = bus_wr && bus_addr == A_SWI;

  always_comb begin
    eset_m   = '0;
    eclr_m   = '0;
    trig_hit = '0;
    for (int w = 0; w < NW; w++) begin
      if (bus_wr && bus_addr == A_ESET + AW'(4 * w)) eset_m[w*32 +: 32] = bus_wdata;
      if (bus_wr && bus_addr == A_ECLR + AW'(4 * w)) eclr_m[w*32 +: 32] = bus_wdata;
      trig_hit[w] = bus_wr && bus_addr == A_TRIG + AW'(4 * w);
    end
  end

  for (genvar s = 0; s < NDEV; s++) begin : g_tgt_wr
    localparam int ID = s + 32;
    assign tgt_we[s] = bus_wr && bus_addr == A_TGT + AW'((ID / 2) * 4);
    assign tgt_wv[s] = bus_wdata[(ID % 2) * 16 +: NUM_CPU];
  end

  always_comb begin
    loc_ack = '0;
    dev_ack = '0;
    sw_set  = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (wr_swi && bus_wdata[8 + c]) sw_set[c] = 16'd1 << bus_wdata[3:0];
      if (ack_vld[c]) begin
        if (ack_id[c*ID_W +: ID_W] < ID_W'(32))
          loc_ack[c] = 32'd1 << ack_id[c*ID_W +: 5];
        for (int s = 0; s < NDEV; s++)
          if (ack_id[c*ID_W +: ID_W] == ID_W'(s + 32)) dev_ack[s] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd      <= 1'b0;
      loc_en   <= '0;
      sw_pend  <= '0;
      loc_q    <= '0;
      loc_edge <= '0;
      trig     <= '0;
      dev_en   <= '0;
      dev_q    <= '0;
      dev_edge <= '0;
      for (int s = 0; s < NDEV; s++) dev_tgt[s] <= '0;
    end else begin
      if (wr_ctrl) fwd <= bus_wdata[0];
      for (int c = 0; c < NUM_CPU; c++) begin
        if (bus_cpu == CPU_W'(c))
          loc_en[c] <= (loc_en[c] | eset_m[31:0]) & ~eclr_m[31:0];
        sw_pend[c]  <= sw_set[c] | (sw_pend[c] & ~loc_ack[c][15:0]);
        loc_q[c]    <= loc_irq[c*16 +: 16];
        loc_edge[c] <= (loc_irq[c*16 +: 16] & ~loc_q[c]) | (loc_edge[c] & ~loc_ack[c][31:16]);
      end
      dev_en   <= (dev_en | eset_m[NUM_IRQ-1:32]) & ~eclr_m[NUM_IRQ-1:32];
      dev_q    <= dev_irq;
      dev_edge <= (dev_irq & ~dev_q) | (dev_edge & ~dev_ack);
      for (int i = 16; i < NUM_IRQ; i++)
        if (trig_hit[i / 32]) trig[i] <= bus_wdata[i % 32];
      for (int s = 0; s < NDEV; s++)
        if (tgt_we[s]) dev_tgt[s] <= tgt_wv[s];
    end
  end

  assign dev_pend = (trig[NUM_IRQ-1:32] & dev_edge) | (~trig[NUM_IRQ-1:32] & dev_q);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [15:0] loc_pend;
    assign loc_pend = (trig[31:16] & loc_edge[c]) | (~trig[31:16] & loc_q[c]);
    assign pend_vec[c*NUM_IRQ +: 16]      = {16{fwd}} & loc_en[c][15:0] & sw_pend[c];
    assign pend_vec[c*NUM_IRQ + 16 +: 16] = {16{fwd}} & loc_en[c][31:16] & loc_pend;
    for (genvar s = 0; s < NDEV; s++) begin : g_dev
      assign pend_vec[c*NUM_IRQ + 32 + s] = fwd & dev_en[s] & dev_pend[s] & dev_tgt[s][c];
    end
  end

  logic [NUM_IRQ-1:0] en_all;
  logic [NUM_IRQ-1:0] trig_all;
  logic [15:0]        self_oh;
  logic [15:0]        tgt_rd [NUM_IRQ];
  logic [31:0]        rd;

  assign en_all   = {dev_en, loc_en[bus_cpu]};
  assign trig_all = {trig, 16'hFFFF};
  assign self_oh  = 16'd1 << bus_cpu;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_tgt_rd
    if (i < 32) begin : g_self
      assign tgt_rd[i] = self_oh;
    end else begin : g_dev
      assign tgt_rd[i] = 16'(dev_tgt[i - 32]);
    end
  end

  always_comb begin
    rd = '0;
    if (bus_addr == A_CTRL) rd = {31'b0, fwd};
    if (bus_addr == A_TYPE) rd = 32'(NW - 1);
    for (int w = 0; w < NW; w++) begin
      if (bus_addr == A_ESET + AW'(4 * w) || bus_addr == A_ECLR + AW'(4 * w))
        rd = en_all[w*32 +: 32];
      if (bus_addr == A_TRIG + AW'(4 * w))
        rd = trig_all[w*32 +: 32];
    end
    for (int k = 0; k < NPAIR; k++)
      if (bus_addr == A_TGT + AW'(4 * k)) rd = {tgt_rd[2*k + 1], tgt_rd[2*k]};
  end

  assign bus_rdata = rd;

endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  parameter int AW = 12,
  localparam int ID_W = $clog2(NUM_IRQ),
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_wr,
  input logic [AW-1:0]              bus_addr,
  input logic [31:0]                bus_wdata,
  input logic [CPU_W-1:0]           bus_cpu,
  input logic [31:0]                bus_rdata,
  input logic [NUM_CPU-1:0]         ack_vld,
  input logic [NUM_CPU*ID_W-1:0]    ack_id,
  input logic [NUM_CPU*NUM_IRQ-1:0] pend_vec
);

  localparam int NW = NUM_IRQ / 32;

  logic [15:0] req_oh;
  assign req_oh = 16'd1 << bus_cpu;

  p_fwd_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h000) && !bus_wdata[0]) |=> (pend_vec == '0));

  p_type_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'('h004)) |-> (bus_rdata == 32'(NW - 1)));

  p_self_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= AW'('h400) && bus_addr < AW'('h440) && bus_addr[1:0] == 2'b00)
      |-> (bus_rdata == {req_oh, req_oh}));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    p_sw_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vld[c] && ack_id[c*ID_W +: ID_W] < ID_W'(16) && !(bus_wr && bus_addr == AW'('h800)))
        |=> (((pend_vec[c*NUM_IRQ +: 16] >> $past(ack_id[c*ID_W +: 4])) & 16'd1) == 16'd0));
    for (genvar w = 1; w < NW; w++) begin : g_w
      p_en_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'('h180 + 4 * w))
          |=> ((pend_vec[c*NUM_IRQ + w*32 +: 32] & $past(bus_wdata)) == 32'd0));
    end
  end

endmodule

bind irq_dist irq_dist_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
  .ack_vld(ack_vld), .ack_id(ack_id), .pend_vec(pend_vec)
);

// File: tb/irq_dist_tb.sv
module irq_dist_tb;
  localparam int NI = 64;
  localparam int NC = 4;
  localparam int AW = 12;
  localparam int IDW = 6;
  localparam int NW = NI / 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0] bus_cpu = '0;
  logic [31:0] bus_rdata;
  logic [NI-33:0] dev_irq = '0;
  logic [NC*16-1:0] loc_irq = '0;
  logic [NC-1:0] ack_vld = '0;
  logic [NC*IDW-1:0] ack_id = '0;
  logic [NC*NI-1:0] pend_vec;

  always #10 clk = ~clk;

  irq_dist #(.NUM_IRQ(NI), .NUM_CPU(NC), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
    .dev_irq(dev_irq), .loc_irq(loc_irq), .ack_vld(ack_vld), .ack_id(ack_id),
    .pend_vec(pend_vec)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_fwd;
  bit m_loc_en [NC][32];
  bit m_sw [NC][16];
  bit m_lq [NC][16];
  bit m_le [NC][16];
  bit m_den [NI];
  bit m_dq [NI];
  bit m_de [NI];
  bit m_trig [NI];
  int m_tgt [NI];

  always @(posedge clk) begin : model
    int a, w, k, id, aid;
    bit line, ackd;
    a = int'(bus_addr);
    if (!rst_n) begin
      m_fwd = 0;
      for (int c = 0; c < NC; c++) begin
        for (int j = 0; j < 32; j++) m_loc_en[c][j] = 0;
        for (int j = 0; j < 16; j++) begin m_sw[c][j] = 0; m_lq[c][j] = 0; m_le[c][j] = 0; end
      end
      for (int i = 0; i < NI; i++) begin
        m_den[i] = 0; m_dq[i] = 0; m_de[i] = 0; m_tgt[i] = 0; m_trig[i] = (i < 16);
      end
    end else begin
      if (bus_wr) begin
        if (a == 0) m_fwd = bus_wdata[0];
        if (a >= 'h100 && a < 'h100 + 4 * NW) begin
          w = (a - 'h100) / 4;
          for (int b = 0; b < 32; b++) if (bus_wdata[b]) begin
            id = w * 32 + b;
            if (id < 32) m_loc_en[bus_cpu][id] = 1; else m_den[id] = 1;
          end
        end
        if (a >= 'h180 && a < 'h180 + 4 * NW) begin
          w = (a - 'h180) / 4;
          for (int b = 0; b < 32; b++) if (bus_wdata[b]) begin
            id = w * 32 + b;
            if (id < 32) m_loc_en[bus_cpu][id] = 0; else m_den[id] = 0;
          end
        end
        if (a >= 'h200 && a < 'h200 + 4 * NW) begin
          w = (a - 'h200) / 4;
          for (int b = 0; b < 32; b++) begin
            id = w * 32 + b;
            if (id >= 16) m_trig[id] = bus_wdata[b];
          end
        end
        if (a >= 'h400 && a < 'h400 + 2 * NI) begin
          k = (a - 'h400) / 4;
          for (int h = 0; h < 2; h++) begin
            id = 2 * k + h;
            if (id >= 32) m_tgt[id] = int'((bus_wdata >> (16 * h)) & ((1 << NC) - 1));
          end
        end
      end
      for (int c = 0; c < NC; c++) begin
        aid = int'(ack_id[c*IDW +: IDW]);
        for (int j = 0; j < 16; j++) begin
          if (ack_vld[c] && aid == j) m_sw[c][j] = 0;
          if (bus_wr && a == 'h800 && bus_wdata[8 + c] && int'(bus_wdata[3:0]) == j) m_sw[c][j] = 1;
          line = loc_irq[c*16 + j];
          if (ack_vld[c] && aid == 16 + j) m_le[c][j] = 0;
          if (line && !m_lq[c][j]) m_le[c][j] = 1;
          m_lq[c][j] = line;
        end
      end
      for (int i = 32; i < NI; i++) begin
        line = dev_irq[i - 32];
        ackd = 0;
        for (int c = 0; c < NC; c++)
          if (ack_vld[c] && int'(ack_id[c*IDW +: IDW]) == i) ackd = 1;
        if (ackd) m_de[i] = 0;
        if (line && !m_dq[i]) m_de[i] = 1;
        m_dq[i] = line;
      end
    end
  end

  function automatic bit exp_bit(int c, int id);
    if (!m_fwd) return 0;
    if (id < 16) return m_loc_en[c][id] && m_sw[c][id];
    if (id < 32) return m_loc_en[c][id] && (m_trig[id] ? m_le[c][id-16] : m_lq[c][id-16]);
    return m_den[id] && (m_trig[id] ? m_de[id] : m_dq[id]) && m_tgt[id][c];
  endfunction

  // R11: full pending vector compared against the model every cycle
  always @(negedge clk) begin : cmp
    logic [NC*NI-1:0] e;
    if (rst_n) begin
      for (int c = 0; c < NC; c++)
        for (int i = 0; i < NI; i++) e[c*NI + i] = exp_bit(c, i);
      n_chk++;
      if (e !== pend_vec) begin
        n_fail++;
        $display("FAIL R11 pend_vec actual=%h expected=%h", pend_vec, e);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input int cpu);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d; bus_cpu = 2'(cpu);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input int cpu, input logic [31:0] exp, input string tag);
    bus_addr = AW'(a); bus_cpu = 2'(cpu);
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic ack(input int c, input int id);
    ack_vld[c] = 1'b1; ack_id[c*IDW +: IDW] = IDW'(id);
    @(negedge clk);
    ack_vld = '0;
  endtask

  function automatic logic [31:0] pb(int c, int id);
    return {31'b0, pend_vec[c*NI + id]};
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 pend_vec zero", {31'b0, |pend_vec}, 32'd0);
    rd('h000, 0, 32'd0, "R1 ctrl");
    rd('h104, 0, 32'd0, "R1 enables");
    rd('h440, 0, 32'd0, "R1 targets");
    rd('h204, 0, 32'd0, "R1 trigger");

    rd('h004, 0, 32'd1, "R7 type");
    wr('h004, 32'hFFFF_FFFF, 0);
    rd('h004, 0, 32'd1, "R7 write ignored");

    wr('h000, 32'd1, 0);
    rd('h000, 0, 32'd1, "R8 ctrl on");

    wr('h104, 32'd5, 0);
    rd('h104, 0, 32'd5, "R2 set");
    rd('h184, 3, 32'd5, "R2 clear word reads enables");
    wr('h104, 32'd0, 0);
    rd('h104, 0, 32'd5, "R2 zero write");
    wr('h184, 32'd1, 0);
    rd('h104, 0, 32'd4, "R2 clear");
    wr('h104, 32'd1, 0);

    wr('h440, 32'hFFFF_0003, 0);
    rd('h440, 0, 32'h000F_0003, "R5 absent cpu bits");
    wr('h444, 32'h0000_0008, 0);
    rd('h444, 0, 32'h0000_0008, "R5 even half");

    dev_irq[0] = 1'b1;
    @(negedge clk);
    check("R4 level cpu0", pb(0, 32), 32'd1);
    check("R5 route cpu1", pb(1, 32), 32'd1);
    check("R5 route cpu2 off", pb(2, 32), 32'd0);
    ack(0, 32);
    check("R4 level ignores ack", pb(0, 32), 32'd1);
    dev_irq[0] = 1'b0;
    @(negedge clk);
    check("R4 level drops", pb(0, 32), 32'd0);

    wr('h204, 32'd1, 0);
    dev_irq[0] = 1'b1; @(negedge clk);
    dev_irq[0] = 1'b0; @(negedge clk);
    check("R4 edge latch", pb(0, 32), 32'd1);
    ack(1, 32);
    check("R12 ack from other cpu", pb(0, 32), 32'd0);
    check("R12 ack cpu1 view", pb(1, 32), 32'd0);
    dev_irq[0] = 1'b1; @(negedge clk);
    dev_irq[0] = 1'b0; @(negedge clk);
    dev_irq[0] = 1'b1;
    ack_vld[0] = 1'b1; ack_id[0 +: IDW] = IDW'(32);
    @(negedge clk);
    ack_vld = '0; dev_irq[0] = 1'b0;
    check("R4 rise beats ack", pb(0, 32), 32'd1);

    dev_irq[2] = 1'b1;
    @(negedge clk);
    check("R5 id34 cpu3", pb(3, 34), 32'd1);
    check("R5 id34 cpu0 off", pb(0, 34), 32'd0);
    dev_irq[2] = 1'b0;

    rd('h200, 0, 32'h0000_FFFF, "R3 fixed bits");
    wr('h200, 32'd0, 0);
    rd('h200, 0, 32'h0000_FFFF, "R3 fixed write ignored");
    wr('h200, 32'hFFFF_FFFF, 0);
    rd('h200, 0, 32'hFFFF_FFFF, "R3 private edge");
    wr('h200, 32'd0, 0);
    rd('h200, 0, 32'h0000_FFFF, "R3 restore");

    wr('h100, 32'h0001_0008, 1);
    rd('h100, 1, 32'h0001_0008, "R10 own bank");
    rd('h100, 0, 32'd0, "R10 other bank");
    wr('h800, (32'd6 << 8) | 32'd3, 0);
    check("R9 raise cpu1", pb(1, 3), 32'd1);
    check("R9 cpu2 not enabled", pb(2, 3), 32'd0);
    check("R9 cpu0 not listed", pb(0, 3), 32'd0);
    wr('h100, 32'd8, 2);
    check("R10 latched shows on enable", pb(2, 3), 32'd1);
    ack(1, 3);
    check("R10 ack cpu1", pb(1, 3), 32'd0);
    check("R10 cpu2 untouched", pb(2, 3), 32'd1);
    ack_vld[1] = 1'b1; ack_id[IDW +: IDW] = IDW'(3);
    wr('h800, (32'd2 << 8) | 32'd3, 0);
    ack_vld = '0;
    check("R9 raise beats ack", pb(1, 3), 32'd1);
    ack(1, 3);
    check("R9 ack clears", pb(1, 3), 32'd0);

    rd('h400, 2, 32'h0004_0004, "R6 self mask cpu2");
    wr('h400, 32'hFFFF_FFFF, 0);
    rd('h400, 0, 32'h0001_0001, "R6 write ignored");
    rd('h41C, 3, 32'h0008_0008, "R6 self mask cpu3");
    loc_irq[16] = 1'b1;
    wr('h100, 32'h0001_0000, 0);
    check("R6 private line own cpu", pb(1, 16), 32'd1);
    check("R10 private line not cpu0", pb(0, 16), 32'd0);
    loc_irq[16] = 1'b0;
    @(negedge clk);

    ack(0, 32);
    wr('h000, 32'd0, 0);
    check("R8 off", {31'b0, |pend_vec}, 32'd0);
    dev_irq[0] = 1'b1; @(negedge clk);
    dev_irq[0] = 1'b0; @(negedge clk);
    check("R8 off while edge", {31'b0, |pend_vec}, 32'd0);
    wr('h000, 32'd1, 0);
    check("R8 latched while off", pb(0, 32), 32'd1);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule